// File: doc/BRIEF.md
# Debug Halt Indicator Counter Pair

This block turns a "core is halted by the debugger" condition into a steady logic level on one output pin. It holds two counters. The master counter has a very short period and can be frozen by the debug-halt input. The slave counter ignores debug halt and produces a PWM compare output.

Each time the master wraps, it raises a trigger that clears the slave. With the master period set to two cycles and the slave compare value set to 2, the slave never climbs far enough to switch its output, so the pin stays low while the master runs. Once the master freezes, the slave runs freely and the pin goes high. Only a short low window equal to the compare value remains at the start of each slave period.

All periods, the compare value, the output polarity and the two enables are plain configuration inputs. The pin is driven from a register.

Top module: `halt_beacon`

## Requirements
- R1: The master counter counts 0 up to `mst_reload`, then returns to 0. It advances only when `mst_en` is 1 and `dbg_halt` is 0. It raises its trigger during the cycle in which its count equals `mst_reload` and it is advancing. With `mst_reload`=3, `slv_cmp`=2 and the slave running, the pin repeats 2 cycles low then 2 cycles high. With `mst_en`=0, the pin goes high as it does in halt.
- R2: While `dbg_halt` is 1, the master holds its count and raises no trigger, but the slave keeps counting. After `dbg_halt` returns to 0, the pin is low again within 4 cycles and stays low.
- R3: A master trigger clears the slave count to 0 at the same clock edge at which the master wraps. The trigger takes precedence over the slave's own counting.
- R4: The slave counts 0 up to `slv_reload`, then returns to 0, so its period is `slv_reload`+1 cycles. With `slv_en`=0, the slave holds its count and ignores triggers, so the pin holds its level.
- R5: Before polarity is applied, the compare output is 0 while the slave count is below `slv_cmp` and 1 from `slv_cmp` onward. The pin shows this value one clock after the count.
- R6: With `pin_invert`=1, the pin is the inverse of the compare output.
- R7: With `mst_reload`=1, `slv_cmp`=2 and both counters enabled, the pin stays low while the master runs.
- R8: When halt is asserted in the R7 setup, the pin goes high within 4 cycles. After that, each slave period shows exactly `slv_cmp` low cycles followed by `slv_reload`+1-`slv_cmp` high cycles.
- R9: While `rst_n` is 0, both counters and the pin are 0.
- R10: With `slv_cmp`=0 and `pin_invert`=0, the pin is high whether the master runs or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_halt | input | 1 | Debug halt; freezes the master counter |
| mst_en | input | 1 | Master counter enable |
| slv_en | input | 1 | Slave counter enable |
| mst_reload | input | W | Master wrap value |
| slv_reload | input | W | Slave wrap value |
| slv_cmp | input | W | Slave compare threshold |
| pin_invert | input | 1 | Output polarity inversion |
| halt_pin | output | 1 | Registered indicator output |

## Verification
The bench measures exact low-run and high-run lengths on the pin during halt. A slave that wraps one count late, or a compare that uses the wrong bound, shifts these lengths by one cycle. It checks that the pin stays low for long stretches while the master runs. A slave reset that lands one edge late lets the count reach 2, which shows up as periodic high glitches. Frozen-slave and enable-off cases catch a slave that still counts, or that is still cleared by triggers, while disabled. Halt entry and release are timed against a fixed latency bound, and the polarity and zero-compare cases confirm the pin level directly.

// File: rtl/hb_pkg.sv
package hb_pkg;
    // Default counter width shared by all units of the indicator.
    localparam int unsigned HB_DEF_W = 16;
endpackage

// File: rtl/hb_master.sv
module hb_master #(
    parameter int unsigned W = hb_pkg::HB_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         halt,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         trig
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } mst_state_t;

    mst_state_t st_d, st_q;
    logic       run;

    always_comb begin
        run  = en && !halt;
        trig = run && (st_q.cnt == reload);
        st_d = st_q;
        if (run) begin
            if (st_q.cnt == reload) st_d.cnt = '0;
            else                    st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/hb_slave.sv
module hb_slave #(
    parameter int unsigned W = hb_pkg::HB_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         trig,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } slv_state_t;

    slv_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (trig)                     st_d.cnt = '0;
            else if (st_q.cnt == reload)  st_d.cnt = '0;
            else                          st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/hb_outreg.sv
module hb_outreg #(
    parameter int unsigned W = hb_pkg::HB_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic         invert,
    output logic         pin
);
    typedef struct packed {
        logic pin;
    } out_state_t;

    out_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        hit        = (cnt >= cmp);
        st_d.pin   = hit ^ invert;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin = st_q.pin;
endmodule

// File: rtl/halt_beacon.sv
module halt_beacon #(
    parameter int unsigned W = hb_pkg::HB_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dbg_halt,
    input  logic         mst_en,
    input  logic         slv_en,
    input  logic [W-1:0] mst_reload,
    input  logic [W-1:0] slv_reload,
    input  logic [W-1:0] slv_cmp,
    input  logic         pin_invert,
    output logic         halt_pin
);
    logic [W-1:0] m_cnt;
    logic [W-1:0] s_cnt;
    logic         trig;

    hb_master #(.W(W)) u_mst (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (mst_en),
        .halt   (dbg_halt),
        .reload (mst_reload),
        .cnt    (m_cnt),
        .trig   (trig)
    );

    hb_slave #(.W(W)) u_slv (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (slv_en),
        .trig   (trig),
        .reload (slv_reload),
        .cnt    (s_cnt)
    );

    hb_outreg #(.W(W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt    (s_cnt),
        .cmp    (slv_cmp),
        .invert (pin_invert),
        .pin    (halt_pin)
    );
endmodule

// File: rtl/hb_checker.sv
module hb_checker #(
    parameter int unsigned W = hb_pkg::HB_DEF_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         halt,
    input logic         m_en,
    input logic         s_en,
    input logic [W-1:0] m_reload,
    input logic [W-1:0] m_cnt,
    input logic         trig,
    input logic [W-1:0] s_cnt,
    input logic [W-1:0] cmp,
    input logic         inv,
    input logic         pin
);
    assert_master_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_en && !halt && m_cnt == m_reload) |=> (m_cnt == '0));

    assert_master_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(m_cnt));

    assert_no_trig_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !trig);

    assert_slave_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && s_en) |=> (s_cnt == '0));

    assert_slave_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !s_en |=> $stable(s_cnt));

    assert_pin_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pin == (($past(s_cnt) >= $past(cmp)) ^ $past(inv))));
endmodule

bind halt_beacon hb_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (dbg_halt),
    .m_en     (mst_en),
    .s_en     (slv_en),
    .m_reload (mst_reload),
    .m_cnt    (m_cnt),
    .trig     (trig),
    .s_cnt    (s_cnt),
    .cmp      (slv_cmp),
    .inv      (pin_invert),
    .pin      (halt_pin)
);

// File: tb/sim_halt_beacon.sv
`timescale 1ns/1ps
module sim_halt_beacon;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dbg_halt = 1'b0;
    logic         mst_en = 1'b0;
    logic         slv_en = 1'b0;
    logic [W-1:0] mst_reload = 16'd1;
    logic [W-1:0] slv_reload = 16'd15;
    logic [W-1:0] slv_cmp = 16'd2;
    logic         pin_invert = 1'b0;
    logic         halt_pin;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    halt_beacon #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt),
        .mst_en(mst_en), .slv_en(slv_en),
        .mst_reload(mst_reload), .slv_reload(slv_reload),
        .slv_cmp(slv_cmp), .pin_invert(pin_invert),
        .halt_pin(halt_pin)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_for(input logic lvl, input int max, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < max; i++) begin
            if (halt_pin == lvl) begin ok = 1'b1; return; end
            @(negedge clk);
        end
        if (halt_pin == lvl) ok = 1'b1;
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (halt_pin == lvl && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_level(input logic lvl, input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            if (halt_pin == lvl) n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        mst_en = 1'b1; slv_en = 1'b1; pin_invert = 1'b1;
        repeat (3) @(negedge clk);
        check(halt_pin == 1'b0, "R9", halt_pin, 0);
        pin_invert = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_running_low();
        int n;
        count_level(1'b1, 60, n);
        check(n == 0, "R7", n, 0);
    endtask

    task automatic t_halt();
        bit ok; int n;
        dbg_halt = 1'b1;
        wait_for(1'b1, 4, ok);
        check(ok, "R8 entry", halt_pin, 1);
        wait_for(1'b0, 40, ok);
        run_len(1'b0, n);
        check(n == 2, "R8 low run", n, 2);
        run_len(1'b1, n);
        check(n == 14, "R4 high run", n, 14);
        run_len(1'b0, n);
        check(n == 2, "R8 second low run", n, 2);
        dbg_halt = 1'b0;
        @(negedge clk);
        wait_for(1'b0, 4, ok);
        check(ok, "R2 release", halt_pin, 0);
        count_level(1'b1, 50, n);
        check(n == 0, "R2 stays low", n, 0);
    endtask

    task automatic t_master_period();
        bit ok; int n;
        mst_reload = 16'd3;
        repeat (10) @(negedge clk);
        wait_for(1'b1, 20, ok);
        wait_for(1'b0, 20, ok);
        run_len(1'b0, n);
        check(n == 2, "R1 low run", n, 2);
        run_len(1'b1, n);
        check(n == 2, "R1 high run", n, 2);
        mst_reload = 16'd1;
        repeat (6) @(negedge clk);
        count_level(1'b1, 30, n);
        check(n == 0, "R1 restore", n, 0);
    endtask

    task automatic t_master_en();
        bit ok; int n;
        mst_en = 1'b0;
        wait_for(1'b1, 4, ok);
        check(ok, "R1 disabled", halt_pin, 1);
        mst_en = 1'b1;
        repeat (5) @(negedge clk);
        count_level(1'b1, 30, n);
        check(n == 0, "R1 reenabled", n, 0);
    endtask

    task automatic t_slave_hold();
        bit ok; int n;
        dbg_halt = 1'b1;
        wait_for(1'b1, 4, ok);
        slv_en = 1'b0;
        @(negedge clk);
        dbg_halt = 1'b0;
        count_level(1'b1, 40, n);
        check(n == 40, "R4 hold", n, 40);
        slv_en = 1'b1;
        repeat (6) @(negedge clk);
        count_level(1'b1, 30, n);
        check(n == 0, "R3 clear resumes", n, 0);
    endtask

    task automatic t_invert();
        bit ok; int n;
        pin_invert = 1'b1;
        repeat (2) @(negedge clk);
        count_level(1'b1, 30, n);
        check(n == 30, "R6 running", n, 30);
        dbg_halt = 1'b1;
        wait_for(1'b0, 40, ok);
        wait_for(1'b1, 40, ok);
        run_len(1'b1, n);
        check(n == 2, "R6 halted high run", n, 2);
        run_len(1'b0, n);
        check(n == 14, "R6 halted low run", n, 14);
        dbg_halt = 1'b0;
        pin_invert = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_compare();
        bit ok; int n;
        slv_cmp = 16'd5;
        dbg_halt = 1'b1;
        wait_for(1'b1, 40, ok);
        wait_for(1'b0, 40, ok);
        run_len(1'b0, n);
        check(n == 5, "R5 low run", n, 5);
        run_len(1'b1, n);
        check(n == 11, "R5 high run", n, 11);
        slv_cmp = 16'd0;
        dbg_halt = 1'b0;
        repeat (2) @(negedge clk);
        count_level(1'b1, 40, n);
        check(n == 40, "R10 running", n, 40);
        dbg_halt = 1'b1;
        count_level(1'b1, 40, n);
        check(n == 40, "R10 halted", n, 40);
        dbg_halt = 1'b0;
        slv_cmp = 16'd2;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        repeat (4) @(negedge clk);
        t_running_low();
        t_halt();
        t_master_period();
        t_master_en();
        t_slave_hold();
        t_invert();
        t_compare();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule